// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one output-compare channel attached to its own up-counting timer. The counter either runs over its full range or wraps back to zero after a programmable limit. Software loads a compare value, one byte at a time, through a small byte-wide register port. Whenever the counter holds that value, the channel raises an event flag. It also applies a chosen action to its pin: drive it low, drive it high, toggle it, or leave it alone.

The compare value first collects in a holding buffer and moves to the active register as one word. The moment of that move depends on whether the timer is running. The event flag uses a two-step clear: software must read it while it is set, then write zero to it. The timer owns the pin only while the timer runs and the channel is in compare mode with a real action. At every other time the pin shows the level from general-purpose I/O. While the timer does not own the pin, the timer's copy of the pin follows that level, so a handover never changes the pin by itself.

Register map (byte addresses): 0 timer control (bits 1:0 clock select, 00 stopped, any other code counts every clock), 1/2 counter high/low, 3/4 limit high/low, 5 channel control, 6/7 compare high/low. Channel control holds: bit 7 event flag, bit 4 compare-mode enable, bits 1:0 pin action (00 none, 01 low, 10 high, 11 toggle). All other bits read as zero. Compare reads return the active compare register.

The holding buffer runs a state machine. Its states are EMPTY (no byte held), HAVE_HI (high byte held), HAVE_LO (low byte held) and PEND (both bytes held, commit due). It moves EMPTY→HAVE_HI on a high-byte write and EMPTY→HAVE_LO on a low-byte write. It moves HAVE_HI→EMPTY or HAVE_LO→EMPTY when the missing byte arrives while the timer is stopped, committing the word on that same edge. It moves HAVE_HI→PEND or HAVE_LO→PEND when the missing byte arrives while the timer runs. It moves PEND→EMPTY on the next edge and commits then, or goes PEND→HAVE_x if a fresh byte arrives on that edge.

The event flag runs a second state machine with states CLR (flag low), SET (flag high) and ARMED (flag high and already read). Its transitions are: CLR→SET on an event; SET→ARMED when the channel control register is read; ARMED→CLR when zero is written to bit 7 and no event occurs on that edge.

Top module: `ocmp_top`

## Requirements
- R1: After reset the counter, limit and compare registers read 0, the flag reads 0, `timer_owns` is 0 and `pin_out` equals `gpio_level`.
- R2: While the clock select is 00 the counter holds its value. Otherwise it increments once per clock. A write to either counter byte sets the counter to 0.
- R3: With a limit of 0 the counter goes from 0xFFFF to 0. With a nonzero limit M it goes from M to 0.
- R4: When the timer runs, compare mode is enabled and the counter equals the active compare value, the flag reads 1 from the next clock on.
- R5: On that event the pin takes the action selected by code 01 (low), 10 (high) or 11 (toggle).
- R6: A zero written to flag bit 7 clears the flag only if the channel control register was read while the flag was set. Without that read the flag stays 1.
- R7: Writing only one byte of the compare value leaves the active compare value unchanged.
- R8: With the timer stopped, the second byte commits on its own write edge. With the timer running, it commits one clock later.
- R9: With toggle selected, the pin keeps its previous level until the first event, and only then inverts.
- R10: `timer_owns` is 1 only while the timer runs, compare mode is enabled and the action is not 00. Otherwise `pin_out` equals `gpio_level`.
- R11: The action repeats at every later match without the flag being cleared.
- R12: Action code 00 still sets the flag and leaves the pin unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the timer counts on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms the flag clear) |
| bus_addr | input | 3 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| gpio_level | input | 1 | Level from general-purpose I/O |
| pin_out | output | 1 | Level driven onto the pin |
| timer_owns | output | 1 | 1 while the timer controls the pin |

## Verification
The bench builds the block with its default byte width of 8, which gives a 16-bit counter and compare path. At that width, the wrap of a free-running counter from 0xFFFF to 0 takes about 65,536 clocks, which the run can afford. A small limit of 3 or 7 makes the limit wrap and the repeated-match behaviour visible within a few clocks. Every pin action is run against both starting GPIO levels where the outcome differs. Both commit paths of the holding buffer are timed to the exact clock.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } pin_act_e;

    localparam logic [ADDR_W-1:0] A_TCTL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_LIM_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_LIM_LO = 3'd4;
    localparam logic [ADDR_W-1:0] A_CH_CTL = 3'd5;
    localparam logic [ADDR_W-1:0] A_CMP_HI = 3'd6;
    localparam logic [ADDR_W-1:0] A_CMP_LO = 3'd7;

    localparam int FLAG_BIT = 7;
    localparam int MODE_BIT = 4;
endpackage

// File: rtl/ocmp_counter.sv
module ocmp_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt_q
);
    logic at_limit;
    assign at_limit = (limit != '0) && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (run)    cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
    end

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(cnt_q));

    // R3
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr && limit != '0 && cnt_q == limit) |=> (cnt_q == '0));
endmodule

// File: rtl/ocmp_cmpbuf.sv
module ocmp_cmpbuf #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  cmp_q
);
    typedef enum logic [1:0] {CB_EMPTY, CB_HAVE_HI, CB_HAVE_LO, CB_PEND} cb_state_e;

    cb_state_e state, nxt;
    logic [BYTE_W-1:0] hold_hi, hold_lo, hold_hi_n, hold_lo_n;
    logic pair_done;

    assign hold_hi_n = wr_hi ? wdata : hold_hi;
    assign hold_lo_n = wr_lo ? wdata : hold_lo;

    always_comb begin
        nxt       = state;
        pair_done = 1'b0;
        unique case (state)
            CB_EMPTY, CB_PEND: begin
                nxt = CB_EMPTY;
                if (wr_hi)      nxt = CB_HAVE_HI;
                else if (wr_lo) nxt = CB_HAVE_LO;
            end
            CB_HAVE_HI: if (wr_lo) pair_done = 1'b1;
            CB_HAVE_LO: if (wr_hi) pair_done = 1'b1;
        endcase
        if (pair_done) nxt = run ? CB_PEND : CB_EMPTY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CB_EMPTY;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_hi <= '0;
            hold_lo <= '0;
            cmp_q   <= '0;
        end else begin
            hold_hi <= hold_hi_n;
            hold_lo <= hold_lo_n;
            if (state == CB_PEND)        cmp_q <= {hold_hi, hold_lo};
            else if (pair_done && !run)  cmp_q <= {hold_hi_n, hold_lo_n};
        end
    end

    // R7
    half_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CB_EMPTY) |=> $stable(cmp_q));

    // R8
    pend_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CB_PEND) |=> (cmp_q == $past({hold_hi, hold_lo})));
endmodule

// File: rtl/ocmp_chan.sv
module ocmp_chan
    import ocmp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     evt,
    input  pin_act_e act,
    input  logic     owns,
    input  logic     gpio_level,
    input  logic     rd_ctl,
    input  logic     wr_ctl,
    input  logic     wr_flag_val,
    output logic     flag,
    output logic     pin_q
);
    typedef enum logic [1:0] {FL_CLR, FL_SET, FL_ARMED} fl_state_e;

    fl_state_e state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            FL_CLR:   if (evt) nxt = FL_SET;
            FL_SET:   if (rd_ctl) nxt = FL_ARMED;
            FL_ARMED: if (wr_ctl && !wr_flag_val && !evt) nxt = FL_CLR;
            default:  nxt = FL_CLR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FL_CLR;
        else        state <= nxt;
    end

    assign flag = (state != FL_CLR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= 1'b0;
        else if (evt && owns) begin
            unique case (act)
                ACT_NONE:   pin_q <= pin_q;
                ACT_LOW:    pin_q <= 1'b0;
                ACT_HIGH:   pin_q <= 1'b1;
                ACT_TOGGLE: pin_q <= ~pin_q;
            endcase
        end else if (!owns) pin_q <= gpio_level;
    end

    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> ($past(state == FL_ARMED) && $past(wr_ctl)));
endmodule

// File: rtl/ocmp_top.sv
module ocmp_top
    import ocmp_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              gpio_level,
    output logic              pin_out,
    output logic              timer_owns
);
    logic [1:0]        clk_sel;
    logic [BYTE_W-1:0] lim_hi, lim_lo;
    logic              oc_en;
    pin_act_e          act;
    logic [CNT_W-1:0]  cnt, cmp;
    logic              run, evt, flag, pin_q;

    assign run        = (clk_sel != 2'b00);
    assign evt        = run && oc_en && (cnt == cmp);
    assign timer_owns = run && oc_en && (act != ACT_NONE);
    assign pin_out    = timer_owns ? pin_q : gpio_level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_sel <= 2'b00;
            lim_hi  <= '0;
            lim_lo  <= '0;
            oc_en   <= 1'b0;
            act     <= ACT_NONE;
        end else if (bus_wr) begin
            unique case (bus_addr)
                A_TCTL:   clk_sel <= bus_wdata[1:0];
                A_LIM_HI: lim_hi  <= bus_wdata;
                A_LIM_LO: lim_lo  <= bus_wdata;
                A_CH_CTL: begin
                    oc_en <= bus_wdata[MODE_BIT];
                    act   <= pin_act_e'(bus_wdata[1:0]);
                end
                default: ;
            endcase
        end
    end

    ocmp_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clr   (bus_wr && (bus_addr == A_CNT_HI || bus_addr == A_CNT_LO)),
        .limit ({lim_hi, lim_lo}),
        .cnt_q (cnt)
    );

    ocmp_cmpbuf #(.BYTE_W(BYTE_W)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .wr_hi (bus_wr && bus_addr == A_CMP_HI),
        .wr_lo (bus_wr && bus_addr == A_CMP_LO),
        .wdata (bus_wdata),
        .cmp_q (cmp)
    );

    ocmp_chan u_chan (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt         (evt),
        .act         (act),
        .owns        (timer_owns),
        .gpio_level  (gpio_level),
        .rd_ctl      (bus_rd && bus_addr == A_CH_CTL),
        .wr_ctl      (bus_wr && bus_addr == A_CH_CTL),
        .wr_flag_val (bus_wdata[FLAG_BIT]),
        .flag        (flag),
        .pin_q       (pin_q)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_TCTL:   bus_rdata[1:0] = clk_sel;
            A_CNT_HI: bus_rdata = cnt[CNT_W-1:BYTE_W];
            A_CNT_LO: bus_rdata = cnt[BYTE_W-1:0];
            A_LIM_HI: bus_rdata = lim_hi;
            A_LIM_LO: bus_rdata = lim_lo;
            A_CH_CTL: begin
                bus_rdata[FLAG_BIT] = flag;
                bus_rdata[MODE_BIT] = oc_en;
                bus_rdata[1:0]      = act;
            end
            A_CMP_HI: bus_rdata = cmp[CNT_W-1:BYTE_W];
            A_CMP_LO: bus_rdata = cmp[BYTE_W-1:0];
        endcase
    end

    // R4
    evt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag);

    // R5
    act_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && act == ACT_HIGH && !bus_wr) |=> pin_out);

    // R11
    act_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && act == ACT_TOGGLE && !bus_wr) |=> (pin_out != $past(pin_out)));
endmodule

// File: tb/tb_ocmp_top.sv
module tb_ocmp_top;
    import ocmp_pkg::*;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 150000;
    localparam int  CMP_AT     = 6;
    // {action[3:2], gpio[1], expected pin after event[0]}
    localparam logic [3:0] VEC [5] = '{4'b01_1_0, 4'b10_0_1, 4'b11_0_1, 4'b11_1_0, 4'b00_1_1};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       gpio_level = 1'b0;
    logic       pin_out, timer_owns;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    ocmp_top dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .gpio_level(gpio_level), .pin_out(pin_out), .timer_owns(timer_owns)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic peek16(input logic [2:0] a_hi, output logic [15:0] v);
        logic [7:0] h, l;
        peek(a_hi, h);
        peek(a_hi + 3'd1, l);
        v = {h, l};
    endtask

    task automatic flag_now(output logic f);
        logic [7:0] v;
        peek(A_CH_CTL, v);
        f = v[7];
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v16;
        logic [7:0]  v8;
        logic        f;

        gpio_level = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek16(A_CNT_HI, v16); chk("R1 counter", v16, 16'h0);
        peek16(A_LIM_HI, v16); chk("R1 limit", v16, 16'h0);
        peek16(A_CMP_HI, v16); chk("R1 compare", v16, 16'h0);
        peek(A_CH_CTL, v8);    chk("R1 channel ctl", v8, 8'h00);
        chk("R1 owns", timer_owns, 1'b0);
        chk("R1 pin", pin_out, gpio_level);

        // Vector table: R4, R5, R9, R12
        for (int i = 0; i < 5; i++) begin
            wr(A_TCTL, 8'h00);
            wr(A_CNT_LO, 8'h00);
            wr(A_CMP_HI, 8'h00);
            wr(A_CMP_LO, 8'(CMP_AT));
            gpio_level = VEC[i][1];
            rd(A_CH_CTL);
            wr(A_CH_CTL, {6'b000100, VEC[i][3:2]});
            wr(A_TCTL, 8'h01);
            repeat (CMP_AT) @(negedge clk);
            #1;
            flag_now(f);
            chk("R4 flag before match", f, 1'b0);
            chk("R9 pin keeps level before match", pin_out, VEC[i][1]);
            @(negedge clk);
            #1;
            flag_now(f);
            chk("R4 flag after match", f, 1'b1);
            if (VEC[i][3:2] == 2'b00) chk("R12 pin unchanged", pin_out, VEC[i][0]);
            else                      chk("R5 pin action", pin_out, VEC[i][0]);
        end

        // R2 stopped counter holds, write clears, run increments
        wr(A_TCTL, 8'h00);
        peek16(A_CNT_HI, v16);
        repeat (5) @(negedge clk);
        begin
            logic [15:0] w;
            peek16(A_CNT_HI, w);
            chk("R2 hold while stopped", w, v16);
        end
        wr(A_CNT_HI, 8'h5A);
        peek16(A_CNT_HI, v16); chk("R2 write clears", v16, 16'h0);
        wr(A_TCTL, 8'h01);
        repeat (3) @(negedge clk);
        peek16(A_CNT_HI, v16); chk("R2 increments", v16, 16'd3);

        // R3 limit wrap and free-run wrap
        wr(A_TCTL, 8'h00);
        wr(A_LIM_LO, 8'h03);
        wr(A_CNT_LO, 8'h00);
        wr(A_TCTL, 8'h02);
        repeat (3) @(negedge clk);
        peek16(A_CNT_HI, v16); chk("R3 reaches limit", v16, 16'd3);
        @(negedge clk);
        peek16(A_CNT_HI, v16); chk("R3 wraps at limit", v16, 16'd0);
        wr(A_TCTL, 8'h00);
        wr(A_LIM_LO, 8'h00);
        wr(A_CNT_LO, 8'h00);
        wr(A_TCTL, 8'h01);
        repeat (65535) @(negedge clk);
        peek16(A_CNT_HI, v16); chk("R3 free-run top", v16, 16'hFFFF);
        @(negedge clk);
        peek16(A_CNT_HI, v16); chk("R3 free-run wrap", v16, 16'h0);

        // R7, R8 buffered compare update
        wr(A_TCTL, 8'h00);
        wr(A_CMP_HI, 8'hAB);
        wr(A_CMP_LO, 8'hCD);
        peek16(A_CMP_HI, v16); chk("R8 stopped commit", v16, 16'hABCD);
        wr(A_CMP_HI, 8'h12);
        peek16(A_CMP_HI, v16); chk("R7 single byte ignored", v16, 16'hABCD);
        wr(A_CMP_LO, 8'h34);
        peek16(A_CMP_HI, v16); chk("R8 stopped commit on second byte", v16, 16'h1234);
        wr(A_TCTL, 8'h01);
        wr(A_CMP_LO, 8'h55);
        wr(A_CMP_HI, 8'h66);
        peek16(A_CMP_HI, v16); chk("R8 running commit not yet", v16, 16'h1234);
        @(negedge clk);
        peek16(A_CMP_HI, v16); chk("R8 running commit next clock", v16, 16'h6655);

        // R6 flag handshake
        wr(A_TCTL, 8'h00);
        wr(A_CMP_HI, 8'h00);
        wr(A_CMP_LO, 8'h04);
        wr(A_CNT_LO, 8'h00);
        rd(A_CH_CTL);
        wr(A_CH_CTL, 8'h10);
        wr(A_TCTL, 8'h01);
        repeat (6) @(negedge clk);
        flag_now(f); chk("R6 flag set", f, 1'b1);
        wr(A_CH_CTL, 8'h10);
        flag_now(f); chk("R6 write without read keeps flag", f, 1'b1);
        rd(A_CH_CTL);
        wr(A_CH_CTL, 8'h10);
        flag_now(f); chk("R6 read then write clears", f, 1'b0);

        // R10 pin ownership
        wr(A_CH_CTL, 8'h02);
        #1; chk("R10 compare mode off", timer_owns, 1'b0);
        gpio_level = 1'b0; #1;
        chk("R10 pin follows gpio", pin_out, 1'b0);
        wr(A_CH_CTL, 8'h10);
        #1; chk("R10 action none", timer_owns, 1'b0);
        wr(A_CH_CTL, 8'h12);
        #1; chk("R10 owned while running", timer_owns, 1'b1);
        wr(A_TCTL, 8'h00);
        gpio_level = 1'b1; #1;
        chk("R10 stopped releases", timer_owns, 1'b0);
        chk("R10 stopped pin is gpio", pin_out, 1'b1);

        // R11 repeated toggle without clearing the flag
        wr(A_LIM_LO, 8'h07);
        wr(A_CMP_HI, 8'h00);
        wr(A_CMP_LO, 8'h02);
        wr(A_CNT_LO, 8'h00);
        gpio_level = 1'b0;
        wr(A_CH_CTL, 8'h13);
        wr(A_TCTL, 8'h01);
        repeat (3) @(negedge clk);
        #1; chk("R11 first toggle", pin_out, 1'b1);
        repeat (8) @(negedge clk);
        #1; chk("R11 second toggle", pin_out, 1'b0);
        repeat (8) @(negedge clk);
        #1; chk("R11 third toggle", pin_out, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule